// File: doc/BRIEF.md
# Pipelined Flow-Through Synchronous SRAM

This block is a single-port synchronous memory whose words are four 9-bit bytes. The bus protocol has no turnaround gap. Address and control are captured on one rising edge, and the data for that operation moves in the following cycle. The bus can therefore carry a read, a write and then a read again with no idle cycle between them. Read data is not registered: during the data cycle it flows from the storage lanes straight to `dq_out`.

An operation starts in a load cycle. Advance/load must be low and all three chip selects must be active. A cycle with advance/load high continues the current transfer as a four-beat burst. The burst walks the two low address bits in either linear or XOR order, and a separate address generator produces that sequence. A clock enable can freeze the whole pipeline. A sleep input gates every state change and turns the drivers off. An output enable, which acts without the clock, turns off the data drivers. The bidirectional bus is split into `dq_in`, `dq_out` and the drive enable `dq_oe`.

Top module: `pipe_flow_sram`

## Requirements
- R1: A read loaded on an edge (adv low, selected, rd_wr high) drives `dq_oe` high during the next cycle, with `dq_out` equal to the stored word at that address.
- R2: For a write, bit i of `byte_we_n` sampled with the control selects byte i (`dq_in` bits 9i+8 down to 9i). The selected bytes are taken from `dq_in` on the edge that ends the data cycle. Unselected bytes keep their old value.
- R3: When `clk_en_n` is high on an edge, every input is ignored and no pipeline state, burst state or stored byte changes.
- R4: A load needs adv low, `sel1_n` low, `sel2` high and `sel3_n` low. If adv is low and any select is inactive, that edge starts a deselect cycle and nothing is driven in the following cycle.
- R5: A write pending when a deselect is sampled still completes with the data presented in that deselect cycle.
- R6: `dq_oe` is low in the cycle after a write load and in the cycle after a deselect.
- R7: `out_en_n` high forces `dq_oe` low immediately. The pending read is kept, so the data reappears when `out_en_n` falls.
- R8: With `sleep` high, no edge changes any state, stored data is retained and `dq_oe` is low.
- R9: A read loaded right after a write to the same address returns the newly written bytes with no extra cycle.
- R10: With `burst_ilv` low, beat n of a burst (n = 0..3) uses low address bits (base + n) mod 4. The upper bits stay those of the base address.
- R11: With `burst_ilv` high, beat n uses low address bits base XOR n. The upper bits are unchanged.
- R12: An edge with adv high and no transfer in progress (after reset or a deselect) starts nothing.
- R13: Byte enables are ignored on reads: a read cycle leaves every stored byte unchanged.
- R14: While `rst_n` is low and after its release, no transfer is pending and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel1_n | input | 1 | Active-low chip select |
| sel2 | input | 1 | Active-high chip select |
| sel3_n | input | 1 | Active-low chip select |
| adv | input | 1 | Low loads a new operation, high advances the burst |
| rd_wr | input | 1 | High read, low write, sampled on load cycles |
| byte_we_n | input | BYTES | Active-low per-byte write enables |
| addr | input | ADDR_W | Word address, used on load cycles |
| burst_ilv | input | 1 | Burst order: low linear, high XOR; held static during a burst |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | High gates all state changes and drivers |
| dq_in | input | BYTES*BYTE_W | Write data during a write data cycle |
| dq_out | output | BYTES*BYTE_W | Flow-through read data; zero when not driving |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The assertions assume that `burst_ilv` changes only while no burst is running. They also assume that no input changes at a rising edge, so each property can relate the control sampled on one edge to `dq_oe` and the pending state after it. The bench changes every input one time unit after an edge and toggles the burst order only between bursts. It reads back only addresses it has written, so an uninitialised word never reaches a data comparison.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // all three selects active
  function automatic logic chip_on(input logic s1_n, input logic s2, input logic s3_n);
    return !s1_n && s2 && !s3_n;
  endfunction

  // low two address bits of a burst beat
  function automatic logic [1:0] burst_lane(input logic [1:0] base, input logic [1:0] beat,
                                            input logic ilv);
    if (ilv) return base ^ beat;
    return base + beat;
  endfunction

endpackage

// File: rtl/pfs_burst.sv
module pfs_burst
  import pfs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              load,
  input  logic              adv_go,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] next_addr
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [1:0]        beat_nx;
  logic [ADDR_W-1:0] adv_addr;

  assign beat_nx = beat_q + 2'd1;

  always_comb begin
    adv_addr      = base_q;
    adv_addr[1:0] = burst_lane(base_q[1:0], beat_nx, ilv);
  end

  assign next_addr = load ? addr_in : adv_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (act) begin
      if (load) begin
        base_q <= addr_in;
        beat_q <= '0;
      end else if (adv_go) begin
        beat_q <= beat_nx;
      end
    end
  end

endmodule

// File: rtl/pfs_ctrl.sv
module pfs_ctrl
  import pfs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              adv,
  input  logic              sel_ok,
  input  logic              rd,
  input  logic [BYTES-1:0]  be_n,
  input  logic [ADDR_W-1:0] next_addr,
  output logic              load_w,
  output logic              adv_go_w,
  output logic              desel_w,
  output op_e               pend_op,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [BYTES-1:0]  pend_be
);

  assign load_w   = !adv && sel_ok;
  assign desel_w  = !adv && !sel_ok;
  assign adv_go_w = adv && (pend_op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_op   <= OP_NONE;
      pend_addr <= '0;
      pend_be   <= '0;
    end else if (act) begin
      pend_be <= ~be_n;
      if (load_w) begin
        pend_op   <= rd ? OP_READ : OP_WRITE;
        pend_addr <= next_addr;
      end else if (adv_go_w) begin
        pend_addr <= next_addr;
      end else begin
        pend_op <= OP_NONE;
      end
    end
  end

endmodule

// File: rtl/pfs_array.sv
module pfs_array #(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTES-1:0]        wr_be,
  input  logic [BYTES*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [BYTES*BYTE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) lane_mem[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
    end

    assign rd_data[g*BYTE_W +: BYTE_W] = lane_mem[rd_addr];
  end

endmodule

// File: rtl/pipe_flow_sram.sv
module pipe_flow_sram
  import pfs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    adv,
  input  logic                    rd_wr,
  input  logic [BYTES-1:0]        byte_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burst_ilv,
  input  logic                    out_en_n,
  input  logic                    sleep,
  input  logic [BYTES*BYTE_W-1:0] dq_in,
  output logic [BYTES*BYTE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DATA_W = BYTES * BYTE_W;

  logic              act_w;
  logic              chip_on_w;
  logic              load_w;
  logic              adv_go_w;
  logic              desel_w;
  logic [ADDR_W-1:0] next_addr_w;
  op_e               pend_op_w;
  logic [ADDR_W-1:0] pend_addr_w;
  logic [BYTES-1:0]  pend_be_w;
  logic              pend_valid_w;
  logic              read_pend_w;
  logic              wr_en_w;
  logic [DATA_W-1:0] rd_data_w;

  // an edge counts only when clock enable is low and the block is awake
  assign act_w     = !clk_en_n && !sleep;
  assign chip_on_w = chip_on(sel1_n, sel2, sel3_n);

  pfs_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act_w),
    .load     (load_w),
    .adv_go   (adv_go_w),
    .ilv      (burst_ilv),
    .addr_in  (addr),
    .next_addr(next_addr_w)
  );

  pfs_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act_w),
    .adv      (adv),
    .sel_ok   (chip_on_w),
    .rd       (rd_wr),
    .be_n     (byte_we_n),
    .next_addr(next_addr_w),
    .load_w   (load_w),
    .adv_go_w (adv_go_w),
    .desel_w  (desel_w),
    .pend_op  (pend_op_w),
    .pend_addr(pend_addr_w),
    .pend_be  (pend_be_w)
  );

  assign pend_valid_w = (pend_op_w != OP_NONE);
  assign read_pend_w  = (pend_op_w == OP_READ);
  assign wr_en_w      = act_w && (pend_op_w == OP_WRITE);

  pfs_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk    (clk),
    .wr_en  (wr_en_w),
    .wr_addr(pend_addr_w),
    .wr_be  (pend_be_w),
    .wr_data(dq_in),
    .rd_addr(pend_addr_w),
    .rd_data(rd_data_w)
  );

  assign dq_oe  = read_pend_w && !out_en_n && !sleep;
  assign dq_out = dq_oe ? rd_data_w : '0;

endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              sleep,
  input logic              adv,
  input logic              chip_on,
  input logic              rd_wr,
  input logic              out_en_n,
  input logic              dq_oe,
  input logic              pend_valid,
  input logic [ADDR_W-1:0] pend_addr
);

  logic act;
  assign act = !clk_en_n && !sleep;

  assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !adv && chip_on && rd_wr) |=> (dq_oe == (!out_en_n && !sleep)));

  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!act) |=> ($stable(pend_valid) && $stable(pend_addr)));

  assert_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !adv && !chip_on) |=> (!dq_oe && !pend_valid));

  assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !adv && chip_on && !rd_wr) |=> !dq_oe);

  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_oe);

  assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);

  assert_no_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (act && adv && !pend_valid) |=> !pend_valid);

endmodule

bind pipe_flow_sram pfs_checker #(.ADDR_W(ADDR_W)) u_pfs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en_n  (clk_en_n),
  .sleep     (sleep),
  .adv       (adv),
  .chip_on   (chip_on_w),
  .rd_wr     (rd_wr),
  .out_en_n  (out_en_n),
  .dq_oe     (dq_oe),
  .pend_valid(pend_valid_w),
  .pend_addr (pend_addr_w)
);

// File: tb/pipe_flow_sram_bench.sv
`timescale 1ns/1ps
module pipe_flow_sram_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cen_n = 1'b0;
  logic        s1n = 1'b0, s2 = 1'b1, s3n = 1'b0;
  logic        adv_i = 1'b1;
  logic        rdw = 1'b1;
  logic [3:0]  be_n = 4'h0;
  logic [3:0]  addr_i = 4'h0;
  logic        ilv = 1'b0;
  logic        oe_n = 1'b0;
  logic        slp = 1'b0;
  logic [35:0] din = '0;
  logic [35:0] dq_out;
  logic        dq_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural model state
  logic [35:0] mmem [16];
  bit          mvalid = 0;
  bit          mwr = 0;
  int          mbase = 0, mcnt = 0, maddr = 0;
  logic [3:0]  mbe = '0;
  logic [35:0] pend_wdata = '0;

  always #2.5 clk = ~clk;

  pipe_flow_sram u_pipe_flow_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(cen_n), .sel1_n(s1n), .sel2(s2), .sel3_n(s3n),
    .adv(adv_i), .rd_wr(rdw), .byte_we_n(be_n), .addr(addr_i), .burst_ilv(ilv),
    .out_en_n(oe_n), .sleep(slp), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [35:0] pat(input int a, input int k);
    return {4'(a + k), 32'(a * 32'h01010101) ^ 32'(k * 32'h9E3779B9)};
  endfunction

  task automatic model_edge();
    if (mvalid && mwr)
      for (int b = 0; b < 4; b++)
        if (mbe[b]) mmem[maddr][b*9 +: 9] = din[b*9 +: 9];
    if (!adv_i) begin
      if (!s1n && s2 && !s3n) begin
        mvalid = 1; mwr = !rdw; mbase = int'(addr_i); mcnt = 0; maddr = mbase;
      end else mvalid = 0;
    end else if (mvalid) begin
      mcnt  = (mcnt + 1) % 4;
      maddr = (mbase / 4) * 4 + (ilv ? ((mbase % 4) ^ mcnt) : ((mbase % 4 + mcnt) % 4));
    end
    mbe = ~be_n;
  endtask

  task automatic tick(input string tag);
    logic exp_oe;
    @(posedge clk);
    if (!rst_n) mvalid = 0;
    else if (!cen_n && !slp) model_edge();
    #1;
    exp_oe = mvalid && !mwr && !oe_n && !slp && rst_n;
    checks++;
    if (dq_oe !== exp_oe || (exp_oe && dq_out !== mmem[maddr])) begin
      errors++;
      $display("FAIL %s: dq_oe=%0b dq_out=%h expected dq_oe=%0b dq_out=%h",
               tag, dq_oe, dq_out, exp_oe, exp_oe ? mmem[maddr] : 36'h0);
    end
  endtask

  task automatic op(input logic a_adv, input logic a_rd, input int a_addr,
                    input logic [3:0] a_be, input logic [35:0] wdata, input string tag);
    cen_n = 0; s1n = 0; s2 = 1; s3n = 0;
    adv_i = a_adv; rdw = a_rd; addr_i = 4'(a_addr); be_n = a_be; din = pend_wdata;
    tick(tag);
    pend_wdata = wdata;
  endtask

  task automatic desel(input int which, input string tag);
    cen_n = 0; adv_i = 0; s1n = (which == 0); s2 = (which != 1); s3n = (which == 2);
    din = pend_wdata; rdw = 1; addr_i = 4'hF;
    tick(tag);
    pend_wdata = '0;
    s1n = 0; s2 = 1; s3n = 0;
  endtask

  task automatic stall(input string tag);
    cen_n = 1; adv_i = ~adv_i; rdw = ~rdw; addr_i = ~addr_i; be_n = ~be_n; s1n = ~s1n;
    din = pend_wdata;
    tick(tag);
    cen_n = 0; s1n = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mmem[i] = '0;
    repeat (3) tick("R14 reset");
    rst_n = 1;
    tick("R14 after reset");
    op(1, 1, 0, 4'h0, '0, "R12 advance from idle");
    // fill every word, then read all back (R2 full word, R1)
    for (int a = 0; a < 16; a++) op(0, 0, a, 4'h0, pat(a, 1), "R2 fill");
    for (int a = 0; a < 16; a++) op(0, 1, a, 4'h0, '0, "R1 read sweep");
    // write then immediate read of same word (R9)
    for (int a = 0; a < 16; a += 3) begin
      op(0, 0, a, 4'h0, pat(a, 7), "R6 write start");
      op(0, 1, a, 4'h0, '0, "R9 read after write");
    end
    // byte enable sweep (R2) with reads ignoring byte enables (R13)
    for (int m = 0; m < 16; m++) begin
      op(0, 0, 5, 4'h0, pat(5, 20 + m), "R2 base word");
      op(0, 0, 5, 4'(m), pat(9, 40 + m), "R2 masked write");
      op(0, 1, 5, 4'(~m), '0, "R2 masked read");
      op(0, 1, 5, 4'h0, '0, "R13 read again");
    end
    // bursts in both orders, every base offset (R10, R11)
    for (int o = 0; o < 2; o++) begin
      ilv = o[0];
      for (int b = 8; b < 12; b++) begin
        op(0, 0, b, 4'h0, pat(b, 60 + o), "R10 R11 burst write");
        for (int n = 1; n < 4; n++) op(1, 1, 0, 4'h0, pat(b + n, 70 + o), "R10 R11 burst write");
        desel(0, "R6 after burst");
        op(0, 1, b, 4'h0, '0, o ? "R11 burst read" : "R10 burst read");
        for (int n = 1; n < 4; n++) op(1, 0, 0, 4'h3, '0, o ? "R11 burst read" : "R10 burst read");
        desel(1, "R4 end burst");
        for (int w = 8; w < 12; w++) op(0, 1, w, 4'h0, '0, "R10 R11 word check");
      end
    end
    ilv = 0;
    // clock enable freeze (R3)
    op(0, 1, 2, 4'h0, '0, "R1 read");
    for (int i = 0; i < 3; i++) stall("R3 frozen read");
    op(0, 0, 3, 4'h0, pat(3, 90), "R6 write");
    for (int i = 0; i < 3; i++) stall("R3 frozen write");
    op(0, 1, 3, 4'h0, '0, "R3 write after freeze");
    // deselect with pending write (R4, R5, R6), each select
    for (int s = 0; s < 3; s++) begin
      op(0, 0, 12 + s, 4'h0, pat(s, 100), "R6 write");
      desel(s, "R5 deselect with pending write");
      op(1, 1, 0, 4'h0, '0, "R12 advance after deselect");
      op(0, 1, 12 + s, 4'h0, '0, "R5 read back");
      desel(s, "R4 deselect after read");
    end
    // output enable (R7)
    op(0, 1, 7, 4'h0, '0, "R1 read");
    oe_n = 1; stall("R7 oe high");
    oe_n = 0; stall("R7 oe low again");
    // sleep (R8)
    op(0, 0, 6, 4'h0, pat(6, 120), "R6 write");
    slp = 1; for (int i = 0; i < 3; i++) op(0, 1, 1, 4'h0, pat(6, 120), "R8 asleep");
    slp = 0;
    pend_wdata = pat(6, 120);
    op(0, 1, 6, 4'h0, '0, "R8 wake read");
    slp = 1; op(0, 0, 6, 4'h0, '0, "R8 sleep hides read");
    slp = 0; stall("R8 read after sleep");
    op(0, 1, 1, 4'h0, '0, "R8 retained");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule